// File: doc/BRIEF.md
# Parallel Port Handshake Control Register

This block is the software-facing control and status register of a bidirectional parallel port. The port runs in one of two roles, chosen by a mode input. In host mode the block drives the four host-side handshake lines and reports the five peripheral-side lines. In peripheral mode the roles swap: it drives the four peripheral-side status lines and reports the four host-side lines. All handshake inputs pass through a two-flop synchronizer before software or the error logic sees them.

A write to the control register holds a pair of bits for each output line of the active group. The upper nibble raises lines and the lower nibble lowers them. Because of this, software can move any single line without first reading the register back. The same read word also carries three status bits: a sticky protocol-error flag, a sticky DMA request flag and a live idle indication from the protocol engine. The protocol-error flag is set when, in peripheral mode, the host pulls its select line low while the protocol engine reports that no orderly-termination window is open.

A second register at address 1 holds two interrupt enables and a clear strobe for the protocol-error flag. The interrupt output is a level. It stays asserted while any enabled flag is set.

Top module: `pport_ctl`

## Requirements
- R1: While `rst_n` is low, `ctl_out` and `sts_out` are 4'hF, `irq` and `dma_req` are 0, and both flags and both interrupt enables are clear. After reset is released, the mode register (address 1) reads 8'h00.
- R2: In host mode, a write to address 0 changes `ctl_out` at the next clock edge. Bits 7..4 set lines high and bits 3..0 set lines low. The line order in both nibbles is nAutoFd (`ctl_out[3]`), nStrobe (`[2]`), nSelectIn (`[1]`), nInit (`[0]`).
- R3: A line whose high bit and low bit are both 0 keeps its level. A line whose two bits are both 1 is driven low.
- R4: In peripheral mode, the same write drives `sts_out` instead. The line order is Busy (`[3]`), PError (`[2]`), Select (`[1]`), nFault (`[0]`). The group that is not selected keeps its level during any control write.
- R5: `ctl_oe` is 1 exactly in host mode (`periph_mode`=0), and `sts_oe` is 1 exactly in peripheral mode.
- R6: In host mode, a read of address 0 returns {Busy, PError, Select, nFault, nAck, IllOp, DREQ, Idle} from bit 7 down to bit 0. The pin values used are those seen through the two-flop synchronizer.
- R7: In peripheral mode, a read of address 0 returns {nAutoFd, nStrobe, nSelectIn, nInit, 0, IllOp, DREQ, Idle} from bit 7 down to bit 0.
- R8: IllOp sets when all of the following hold: peripheral mode is active, the synchronized nSelectIn (`ctl_in[1]`) falls, and `term_window` is 0 on the edge where the fall is seen. A fall while `term_window` is 1, or in host mode, leaves IllOp clear.
- R9: IllOp clears only on a write to address 1 with bit 0 = 1. A write to address 1 with bit 0 = 0 leaves IllOp set.
- R10: DREQ sets on `dreq_set`, holds, and clears on `dma_ack`. If both arrive in the same cycle, the set wins. `dma_req` shows DREQ.
- R11: Address 1 holds bit 1 = IllOp interrupt enable and bit 2 = DREQ interrupt enable, and reads back as {5'b0, bit2, bit1, 0}. `irq` is the OR of each enabled flag and stays high until that flag clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| periph_mode | input | 1 | 0 = host role, 1 = peripheral role |
| reg_addr | input | ADDR_W | Register address: 0 control/status, 1 mode |
| reg_wr | input | 1 | Write strobe, one cycle |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` (combinational) |
| ctl_in | input | 4 | Host-side lines as seen on the pins {nAutoFd, nStrobe, nSelectIn, nInit} |
| ctl_out | output | 4 | Host-side line drive values |
| ctl_oe | output | 1 | Host-side line output enable |
| sts_in | input | 4 | Peripheral-side lines as seen on the pins {Busy, PError, Select, nFault} |
| ack_in | input | 1 | nAck line from the peripheral |
| sts_out | output | 4 | Peripheral-side line drive values |
| sts_oe | output | 1 | Peripheral-side line output enable |
| idle_in | input | 1 | Idle indication from the protocol engine |
| term_window | input | 1 | 1 while an orderly-termination window is open |
| dreq_set | input | 1 | Pulse that sets the DMA request flag |
| dma_ack | input | 1 | Pulse that clears the DMA request flag |
| dma_req | output | 1 | DMA request |
| irq | output | 1 | Level interrupt request |

## Verification
The write path is exercised with lower-only, upper-only, all-zero and overlapping nibbles. These patterns separate a set/clear pair from a plain store and show which bit wins a conflict. Each write is repeated in both roles, which shows whether the right line group moves and the other one holds. Falls of nSelectIn are applied with the window open, with it closed and in host mode, to check that IllOp depends on exactly that combination. Mode-register writes with and without the clear bit, and simultaneous DREQ set and acknowledge, check the sticky behaviour and the level interrupt.

// File: rtl/pport_pkg.sv
package pport_pkg;
  localparam int LINES = 4;
  localparam int DW    = 2 * LINES;

  localparam int CTL_ADDR  = 0;
  localparam int MODE_ADDR = 1;

  // position of nSelectIn inside the host-side line group
  localparam int SEL_IDX = 1;

  // mode register fields
  localparam int MODE_CLR_BIT = 0;
  localparam int MODE_STS_IE  = 1;
  localparam int MODE_DRQ_IE  = 2;

  typedef struct packed {
    logic drq_ie;
    logic sts_ie;
  } mode_t;

  // set/clear pair update: a low request beats a high request
  function automatic logic [LINES-1:0] next_drive(
    input logic [LINES-1:0] cur,
    input logic [LINES-1:0] hi,
    input logic [LINES-1:0] lo
  );
    return (cur | hi) & ~lo;
  endfunction

  function automatic logic [DW-1:0] pack_status(
    input logic             periph,
    input logic [LINES-1:0] ctl_s,
    input logic [LINES-1:0] sts_s,
    input logic             ack_s,
    input logic             illop,
    input logic             dreq,
    input logic             idle
  );
    if (periph) return {ctl_s, 1'b0, illop, dreq, idle};
    return {sts_s, ack_s, illop, dreq, idle};
  endfunction

  function automatic logic [DW-1:0] pack_mode(input mode_t m);
    return {{(DW-3){1'b0}}, m.drq_ie, m.sts_ie, 1'b0};
  endfunction
endpackage

// File: rtl/pport_sync.sv
module pport_sync #(
  parameter int         W       = 4,
  parameter int         STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stage_q[i] <= RST_VAL;
    end else begin
      stage_q[0] <= d;
      for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/pport_drive.sv
module pport_drive
  import pport_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [LINES-1:0] hi,
  input  logic [LINES-1:0] lo,
  output logic [LINES-1:0] lines_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     lines_q <= '1;
    else if (wr_en) lines_q <= next_drive(lines_q, hi, lo);
  end
endmodule

// File: rtl/pport_flags.sv
module pport_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic periph,
  input  logic sel_fall,
  input  logic window_open,
  input  logic illop_clr,
  input  logic dreq_set,
  input  logic dreq_ack,
  input  logic sts_ie,
  input  logic drq_ie,
  output logic illop_q,
  output logic dreq_q,
  output logic irq
);
  logic illop_evt;

  assign illop_evt = periph && sel_fall && !window_open;

  // a new error in the same cycle as a clear is kept
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         illop_q <= 1'b0;
    else if (illop_evt) illop_q <= 1'b1;
    else if (illop_clr) illop_q <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        dreq_q <= 1'b0;
    else if (dreq_set) dreq_q <= 1'b1;
    else if (dreq_ack) dreq_q <= 1'b0;
  end

  assign irq = (illop_q && sts_ie) || (dreq_q && drq_ie);
endmodule

// File: rtl/pport_ctl.sv
module pport_ctl
  import pport_pkg::*;
#(
  parameter int ADDR_W      = 1,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              periph_mode,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [DW-1:0]     reg_wdata,
  output logic [DW-1:0]     reg_rdata,
  input  logic [LINES-1:0]  ctl_in,
  output logic [LINES-1:0]  ctl_out,
  output logic              ctl_oe,
  input  logic [LINES-1:0]  sts_in,
  input  logic              ack_in,
  output logic [LINES-1:0]  sts_out,
  output logic              sts_oe,
  input  logic              idle_in,
  input  logic              term_window,
  input  logic              dreq_set,
  input  logic              dma_ack,
  output logic              dma_req,
  output logic              irq
);
  localparam int SYNC_W = 2 * LINES + 2;

  // named internal events
  logic              wr_ctl, wr_mode;
  logic              wr_ctl_host, wr_ctl_periph;
  logic [LINES-1:0]  ctl_s, sts_s;
  logic              ack_s, idle_s;
  logic              sel_prev, sel_fall;
  logic              illop_q, dreq_q;
  mode_t             mode_q;

  assign wr_ctl        = reg_wr && (reg_addr == ADDR_W'(CTL_ADDR));
  assign wr_mode       = reg_wr && (reg_addr == ADDR_W'(MODE_ADDR));
  assign wr_ctl_host   = wr_ctl && !periph_mode;
  assign wr_ctl_periph = wr_ctl &&  periph_mode;

  pport_sync #(
    .W(SYNC_W), .STAGES(SYNC_STAGES), .RST_VAL({{(SYNC_W-1){1'b1}}, 1'b0})
  ) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({ctl_in, sts_in, ack_in, idle_in}),
    .q({ctl_s, sts_s, ack_s, idle_s})
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sel_prev <= 1'b1;
    else        sel_prev <= ctl_s[SEL_IDX];
  end
  assign sel_fall = sel_prev && !ctl_s[SEL_IDX];

  pport_drive u_drv_ctl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_ctl_host),
    .hi(reg_wdata[DW-1:LINES]), .lo(reg_wdata[LINES-1:0]),
    .lines_q(ctl_out)
  );

  pport_drive u_drv_sts (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_ctl_periph),
    .hi(reg_wdata[DW-1:LINES]), .lo(reg_wdata[LINES-1:0]),
    .lines_q(sts_out)
  );

  assign ctl_oe = !periph_mode;
  assign sts_oe =  periph_mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= '0;
    else if (wr_mode) begin
      mode_q.sts_ie <= reg_wdata[MODE_STS_IE];
      mode_q.drq_ie <= reg_wdata[MODE_DRQ_IE];
    end
  end

  pport_flags u_flags (
    .clk(clk), .rst_n(rst_n),
    .periph(periph_mode), .sel_fall(sel_fall), .window_open(term_window),
    .illop_clr(wr_mode && reg_wdata[MODE_CLR_BIT]),
    .dreq_set(dreq_set), .dreq_ack(dma_ack),
    .sts_ie(mode_q.sts_ie), .drq_ie(mode_q.drq_ie),
    .illop_q(illop_q), .dreq_q(dreq_q), .irq(irq)
  );

  assign dma_req = dreq_q;

  always_comb begin
    if (reg_addr == ADDR_W'(MODE_ADDR)) reg_rdata = pack_mode(mode_q);
    else reg_rdata = pack_status(periph_mode, ctl_s, sts_s, ack_s,
                                 illop_q, dreq_q, idle_s);
  end
endmodule

// File: rtl/pport_ctl_chk.sv
module pport_ctl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       periph_mode,
  input logic       wr_ctl,
  input logic       wr_mode,
  input logic [7:0] wdata,
  input logic [3:0] ctl_out,
  input logic [3:0] sts_out,
  input logic       ctl_oe,
  input logic       sts_oe,
  input logic       illop,
  input logic       dreq,
  input logic       dma_ack,
  input logic       irq
);
  // R2
  host_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctl && !periph_mode && (wdata[3:0] != 4'h0)
      |=> (ctl_out & $past(wdata[3:0])) == 4'h0);

  // R3
  host_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctl && !periph_mode
      |=> ((ctl_out | $past(wdata[3:0])) & $past(wdata[7:4])) == $past(wdata[7:4]));

  // R4
  periph_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctl && periph_mode && (wdata[3:0] != 4'h0)
      |=> (sts_out & $past(wdata[3:0])) == 4'h0);

  // R4
  other_group_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ctl |=> $stable(ctl_out) && $stable(sts_out));

  // R4
  host_write_sts_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctl && !periph_mode |=> $stable(sts_out));

  // R5
  oe_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({ctl_oe, sts_oe}) == 1);

  // R8
  illop_only_periph_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(illop) |-> $past(periph_mode));

  // R9
  illop_clear_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(illop) |-> $past(wr_mode && wdata[0]));

  // R10
  dreq_clear_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dreq) |-> $past(dma_ack));

  // R11
  irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> illop || dreq);
endmodule

bind pport_ctl pport_ctl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .periph_mode(periph_mode),
  .wr_ctl(wr_ctl), .wr_mode(wr_mode), .wdata(reg_wdata),
  .ctl_out(ctl_out), .sts_out(sts_out), .ctl_oe(ctl_oe), .sts_oe(sts_oe),
  .illop(illop_q), .dreq(dreq_q), .dma_ack(dma_ack), .irq(irq)
);

// File: tb/pport_ctl_test.sv
`timescale 1ns/1ps
module pport_ctl_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       periph_mode = 1'b0;
  logic [0:0] reg_addr = '0;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic [3:0] ctl_in = 4'hF, ctl_out, sts_in = 4'hF, sts_out;
  logic       ctl_oe, sts_oe, ack_in = 1'b1, idle_in = 1'b0;
  logic       term_window = 1'b0, dreq_set = 1'b0, dma_ack = 1'b0;
  logic       dma_req, irq;

  always #2 clk = ~clk;

  pport_ctl uut (
    .clk(clk), .rst_n(rst_n), .periph_mode(periph_mode),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .ctl_in(ctl_in), .ctl_out(ctl_out),
    .ctl_oe(ctl_oe), .sts_in(sts_in), .ack_in(ack_in), .sts_out(sts_out),
    .sts_oe(sts_oe), .idle_in(idle_in), .term_window(term_window),
    .dreq_set(dreq_set), .dma_ack(dma_ack), .dma_req(dma_req), .irq(irq)
  );

  typedef enum int {K_RDATA, K_CTL, K_STS, K_IRQ, K_DMA, K_OE} kind_t;
  typedef struct {
    kind_t      kind;
    logic [7:0] exp;
    string      tag;
  } item_t;

  item_t sb[$];
  int    errors = 0;
  int    checks = 0;
  bit    done = 0;
  logic [3:0] ctl_m, sts_m;

  function automatic logic [7:0] observe(kind_t k);
    case (k)
      K_RDATA: return reg_rdata;
      K_CTL:   return {4'h0, ctl_out};
      K_STS:   return {4'h0, sts_out};
      K_IRQ:   return {7'h0, irq};
      K_DMA:   return {7'h0, dma_req};
      default: return {6'h0, ctl_oe, sts_oe};
    endcase
  endfunction

  // monitor: compare queued expectations mid-cycle
  always @(negedge clk) begin
    while (sb.size() > 0) begin
      item_t it;
      logic [7:0] act;
      it  = sb.pop_front();
      act = observe(it.kind);
      checks++;
      if (act !== it.exp) begin
        errors++;
        $display("FAIL %s: actual=%h expected=%h", it.tag, act, it.exp);
      end
    end
  end

  // bench's own model of a set/clear write, bit by bit
  function automatic logic [3:0] model_write(logic [3:0] cur, logic [7:0] wd);
    logic [3:0] r;
    r = cur;
    for (int i = 0; i < 4; i++) begin
      if (wd[i])          r[i] = 1'b0;
      else if (wd[i + 4]) r[i] = 1'b1;
    end
    return r;
  endfunction

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic expect_val(kind_t k, logic [7:0] e, string tag);
    item_t it;
    it.kind = k; it.exp = e; it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic reg_write(logic a, logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    tick(1);
    reg_wr = 1'b0;
  endtask

  task automatic ctl_write(logic [7:0] d, string tag);
    reg_write(1'b0, d);
    if (periph_mode) sts_m = model_write(sts_m, d);
    else             ctl_m = model_write(ctl_m, d);
    expect_val(K_CTL, {4'h0, ctl_m}, tag);
    expect_val(K_STS, {4'h0, sts_m}, tag);
    tick(1);
  endtask

  task automatic read_check(logic a, logic [7:0] e, string tag);
    reg_addr = a;
    #0;
    expect_val(K_RDATA, e, tag);
    tick(1);
  endtask

  task automatic summary;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      summary();
    end
  end

  initial begin
    ctl_m = 4'hF;
    sts_m = 4'hF;
    tick(3);
    // R1 reset state
    expect_val(K_CTL, 8'h0F, "R1 ctl_out in reset");
    expect_val(K_STS, 8'h0F, "R1 sts_out in reset");
    expect_val(K_IRQ, 8'h00, "R1 irq in reset");
    expect_val(K_DMA, 8'h00, "R1 dma_req in reset");
    tick(1);
    rst_n = 1'b1;
    tick(3);
    read_check(1'b1, 8'h00, "R1 mode reg after reset");

    // R5 host role enables
    expect_val(K_OE, 8'h02, "R5 host oe");
    tick(1);
    // R6 host read of idle pins
    read_check(1'b0, 8'hF8, "R6 host read idle pins");

    // R2 / R3 host writes
    ctl_write(8'h0A, "R2 lower nAutoFd and nSelectIn");
    ctl_write(8'h80, "R2 raise nAutoFd");
    ctl_write(8'h00, "R3 all-zero write holds");
    ctl_write(8'h11, "R3 both bits set drives low");

    // R6 host read with changed pins
    sts_in = 4'hA; ack_in = 1'b0; idle_in = 1'b1;
    tick(4);
    read_check(1'b0, 8'hA1, "R6 host read pattern");

    // peripheral role
    periph_mode = 1'b1;
    ctl_in = 4'h6;
    tick(4);
    expect_val(K_OE, 8'h01, "R5 peripheral oe");
    tick(1);
    read_check(1'b0, 8'h61, "R7 peripheral read");
    ctl_write(8'h0F, "R4 peripheral lower all status lines");
    ctl_write(8'hA0, "R4 peripheral raise Busy and Select");

    // R11 enable IllOp interrupt
    reg_write(1'b1, 8'h02);
    read_check(1'b1, 8'h02, "R11 mode readback");

    // R8 fall inside window: no error
    term_window = 1'b1;
    ctl_in = 4'h4;
    tick(5);
    read_check(1'b0, 8'h41, "R8 fall in window ignored");
    expect_val(K_IRQ, 8'h00, "R8 no irq in window");
    tick(1);
    ctl_in = 4'h6;
    tick(5);
    term_window = 1'b0;
    ctl_in = 4'h4;
    tick(5);
    read_check(1'b0, 8'h45, "R8 fall outside window sets IllOp");
    expect_val(K_IRQ, 8'h01, "R11 IllOp interrupt");
    tick(1);

    // R9 clear only with bit 0
    reg_write(1'b1, 8'h02);
    read_check(1'b0, 8'h45, "R9 write without clear bit keeps IllOp");
    reg_write(1'b1, 8'h03);
    read_check(1'b0, 8'h41, "R9 clear bit clears IllOp");
    expect_val(K_IRQ, 8'h00, "R11 irq drops with flag");
    tick(1);

    // R8 host role: fall does nothing
    periph_mode = 1'b0;
    ctl_in = 4'h6;
    tick(5);
    ctl_in = 4'h4;
    tick(5);
    read_check(1'b0, 8'hA1, "R8 host-mode fall ignored");

    // R10 DREQ
    dreq_set = 1'b1;
    tick(1);
    dreq_set = 1'b0;
    expect_val(K_DMA, 8'h01, "R10 dreq set");
    expect_val(K_IRQ, 8'h00, "R11 dreq irq disabled");
    tick(1);
    read_check(1'b0, 8'hA3, "R10 dreq in status read");
    reg_write(1'b1, 8'h04);
    expect_val(K_IRQ, 8'h01, "R11 dreq irq enabled");
    tick(1);
    read_check(1'b1, 8'h04, "R11 mode readback dreq enable");
    dreq_set = 1'b1; dma_ack = 1'b1;
    tick(1);
    dreq_set = 1'b0; dma_ack = 1'b0;
    expect_val(K_DMA, 8'h01, "R10 set beats ack");
    tick(1);
    dma_ack = 1'b1;
    tick(1);
    dma_ack = 1'b0;
    expect_val(K_DMA, 8'h00, "R10 ack clears");
    expect_val(K_IRQ, 8'h00, "R11 irq follows dreq clear");
    tick(1);

    // R1 reset mid-run
    rst_n = 1'b0;
    tick(1);
    expect_val(K_CTL, 8'h0F, "R1 ctl_out after reset");
    expect_val(K_STS, 8'h0F, "R1 sts_out after reset");
    expect_val(K_DMA, 8'h00, "R1 dma_req after reset");
    tick(1);
    rst_n = 1'b1;
    tick(3);
    read_check(1'b1, 8'h00, "R1 enables cleared");
    read_check(1'b0, 8'hA1, "R1 flags cleared");

    tick(2);
    done = 1;
    summary();
  end
endmodule